// File: doc/BRIEF.md
# Bus-Attached Byte Memory with Sequential Loader and Full Dump

This block is the storage side of a small teaching processor. A latched address register and a byte-wide RAM share one data bus. Three single-bit controls decide what happens on each clock. One latches the bus value as the next address. One writes the bus byte at the latched address. One places the addressed byte on the bus. Reads are combinational from the latched address, so a byte is visible as soon as the address register changes.

Two engines can take the memory away from the processor. The fill engine stands in for front-panel switches. After a start strobe it writes a stream of bytes into consecutive locations from address zero. The dump engine starts on its own strobe and streams every location in ascending order, with an address and a valid flag. One cycle after the final byte it gives a one-cycle done pulse. While either engine runs, processor requests on the address and write controls are ignored.

The bus value used for address loads is one bit wider than the address. An address load whose value does not fit sets a sticky error flag and leaves the address register unchanged.

Top module: `bus_mem_subsys`

## Requirements
- R1: With neither engine busy, `lm` high at a clock edge loads `bus_in` into `addr_q` if the value is below 256. Without `lm`, and outside fill writes, `addr_q` holds.
- R2: With neither engine busy, `lr` high at a clock edge writes `bus_in[7:0]` at the `addr_q` value from before that edge. This holds even if `lm` changes `addr_q` at the same edge. A clock without `lr` leaves memory unchanged.
- R3: `bus_oe` equals `er`. While `er` is high, `bus_out` shows the byte stored at `addr_q`, combinationally. While `er` is low, `bus_out` is zero.
- R4: After reset, `addr_q` is 0, `addr_err` is 0, both busy flags are 0, and every memory location reads 0.
- R5: An accepted `lm` whose `bus_in` has any bit above bit 7 set raises `addr_err`. The flag stays high until reset, and `addr_q` keeps its previous value.
- R6: `ld_start` with both engines idle raises `ld_busy` from the next cycle. Each later cycle with `ld_valid` writes `ld_byte` at the next address, counting up from 0. That cycle also sets `addr_q` to the address written; cycles without `ld_valid` write nothing. Filling ends after a byte marked `ld_last` or after address 255 is written.
- R7: `dma_go` accepted while idle starts a dump on the next cycle. For 256 consecutive cycles `dump_valid` is high, `dump_addr` runs 0 to 255, and `dump_data` is the byte stored there. `dma_busy` is high for exactly those cycles.
- R8: `dump_done` is high for exactly one cycle, the cycle after the last valid byte, and never together with `dump_valid`.
- R9: While either engine is busy, `lm`, `lr`, `ld_start` and `dma_go` have no effect. If `ld_start` and `dma_go` arrive together while idle, only the fill engine starts. The two busy flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 9 | Bus value; low 8 bits are data, all 9 bits are checked on address loads |
| lm | input | 1 | Load address register from bus |
| lr | input | 1 | Write bus byte into RAM at latched address |
| er | input | 1 | Enable RAM output onto bus |
| bus_out | output | 8 | RAM byte driven to bus, zero when released |
| bus_oe | output | 1 | RAM is driving the bus |
| addr_q | output | 8 | Address register contents |
| addr_err | output | 1 | Sticky out-of-range address flag |
| ld_start | input | 1 | Fill engine start strobe |
| ld_valid | input | 1 | Fill byte present |
| ld_byte | input | 8 | Fill byte |
| ld_last | input | 1 | Fill byte is the final one |
| ld_busy | output | 1 | Fill engine owns the memory |
| dma_go | input | 1 | Dump start strobe |
| dma_busy | output | 1 | Dump engine running |
| dump_valid | output | 1 | Dump byte present |
| dump_addr | output | 8 | Address of dump byte |
| dump_data | output | 8 | Dump byte |
| dump_done | output | 1 | One-cycle end-of-dump pulse |

## Verification
The bench targets a write and an address load in the same cycle. A design that let the write see the new address would store the byte in the wrong place. It applies an out-of-range address load and checks that the address is kept and the flag stays set. A design that truncated the value would quietly move the address. Processor controls and a second strobe are driven while each engine runs, to catch a design that lets a processor write corrupt a fill or restarts a dump midway. A fill that runs to address 255 without a last marker, and a dump of all locations, expose off-by-one endings as a missing or repeated address or a misplaced done pulse.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

  typedef enum logic {FILL_IDLE, FILL_RUN} fill_state_t;
  typedef enum logic {DUMP_IDLE, DUMP_RUN} dump_state_t;

  // True when value v has no bit set at or above position aw.
  function automatic logic addr_in_range(input logic [63:0] v, input int unsigned aw);
    return (v >> aw) == 64'd0;
  endfunction

  // True when a pointer of width aw sits on its final location.
  function automatic logic at_top(input logic [63:0] p, input int unsigned aw);
    return p == ((64'd1 << aw) - 64'd1);
  endfunction

endpackage

// File: rtl/bmem_addr_reg.sv
module bmem_addr_reg
  import bmem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SRC_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ld,
  input  logic [SRC_W-1:0]  cpu_val,
  input  logic              own_ld,
  input  logic [ADDR_W-1:0] own_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              err_q,
  output logic              range_ok
);

  assign range_ok = addr_in_range(64'(cpu_val), ADDR_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      err_q  <= 1'b0;
    end else if (own_ld) begin
      addr_q <= own_addr;
    end else if (cpu_ld) begin
      if (range_ok) addr_q <= cpu_val[ADDR_W-1:0];
      else          err_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/bmem_array.sv
module bmem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/bmem_loader.sv
module bmem_loader
  import bmem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_last,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);

  fill_state_t       state;
  logic [ADDR_W-1:0] ptr;
  logic              final_write;

  assign busy        = (state == FILL_RUN);
  assign we          = busy && in_valid;
  assign waddr       = ptr;
  assign wdata       = in_byte;
  assign final_write = we && (in_last || at_top(64'(ptr), ADDR_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= FILL_IDLE;
      ptr   <= '0;
    end else if (state == FILL_IDLE) begin
      if (start) begin
        state <= FILL_RUN;
        ptr   <= '0;
      end
    end else if (final_write) begin
      state <= FILL_IDLE;
    end else if (we) begin
      ptr <= ptr + 1'b1;
    end
  end

endmodule

// File: rtl/bmem_dumper.sv
module bmem_dumper
  import bmem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              valid,
  output logic              done
);

  dump_state_t       state;
  logic [ADDR_W-1:0] cnt;
  logic              last_beat;

  assign busy      = (state == DUMP_RUN);
  assign valid     = busy;
  assign rd_addr   = cnt;
  assign last_beat = busy && at_top(64'(cnt), ADDR_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= DUMP_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_beat;
      if (state == DUMP_IDLE) begin
        if (start) begin
          state <= DUMP_RUN;
          cnt   <= '0;
        end
      end else if (last_beat) begin
        state <= DUMP_IDLE;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_mem_subsys.sv
module bus_mem_subsys #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SRC_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  bus_in,
  input  logic              lm,
  input  logic              lr,
  input  logic              er,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_err,
  input  logic              ld_start,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_byte,
  input  logic              ld_last,
  output logic              ld_busy,
  input  logic              dma_go,
  output logic              dma_busy,
  output logic              dump_valid,
  output logic [ADDR_W-1:0] dump_addr,
  output logic [DATA_W-1:0] dump_data,
  output logic              dump_done
);

  // Named internal events.
  logic              eng_busy;
  logic              cpu_lm;
  logic              cpu_lr;
  logic              fill_go;
  logic              dump_go;
  logic              fill_we;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] fill_data;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] rd_bus;
  logic              lm_range_ok;

  assign eng_busy = ld_busy | dma_busy;
  assign cpu_lm   = lm & ~eng_busy;
  assign cpu_lr   = lr & ~eng_busy;
  assign fill_go  = ld_start & ~eng_busy;
  assign dump_go  = dma_go & ~eng_busy & ~ld_start;

  assign mem_we    = fill_we | cpu_lr;
  assign mem_waddr = fill_we ? fill_addr : addr_q;
  assign mem_wdata = fill_we ? fill_data : bus_in[DATA_W-1:0];

  assign bus_oe  = er;
  assign bus_out = er ? rd_bus : '0;

  bmem_addr_reg #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_mar (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ld   (cpu_lm),
    .cpu_val  (bus_in),
    .own_ld   (fill_we),
    .own_addr (fill_addr),
    .addr_q   (addr_q),
    .err_q    (addr_err),
    .range_ok (lm_range_ok)
  );

  bmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (addr_q),
    .rdata_a (rd_bus),
    .raddr_b (dump_addr),
    .rdata_b (dump_data)
  );

  bmem_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fill_go),
    .in_valid (ld_valid),
    .in_byte  (ld_byte),
    .in_last  (ld_last),
    .busy     (ld_busy),
    .we       (fill_we),
    .waddr    (fill_addr),
    .wdata    (fill_data)
  );

  bmem_dumper #(.ADDR_W(ADDR_W)) u_dump (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (dump_go),
    .busy    (dma_busy),
    .rd_addr (dump_addr),
    .valid   (dump_valid),
    .done    (dump_done)
  );

endmodule

// File: rtl/bus_mem_subsys_chk.sv
module bus_mem_subsys_chk #(
  parameter int ADDR_W = 8,
  parameter int SRC_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_W-1:0]  bus_in,
  input logic              lm,
  input logic [ADDR_W-1:0] addr_q,
  input logic              addr_err,
  input logic              ld_start,
  input logic              ld_busy,
  input logic              dma_go,
  input logic              dma_busy,
  input logic              dump_valid,
  input logic [ADDR_W-1:0] dump_addr,
  input logic              dump_done
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lm && !ld_busy) |=> $stable(addr_q)); // R1

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err); // R5

  AST_BAD_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lm && !ld_busy && !dma_busy && (bus_in >> ADDR_W) != '0) |=> (addr_err && $stable(addr_q))); // R5

  AST_DUMP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_go && !ld_busy && !dma_busy && !ld_start) |=> (dump_valid && dump_addr == '0)); // R7

  AST_DUMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid && dump_addr != TOP_ADDR) |=> (dump_valid && dump_addr == ADDR_W'($past(dump_addr) + 1'b1))); // R7

  AST_DUMP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid && dump_addr == TOP_ADDR) |=> (dump_done && !dump_valid)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dump_done |=> !dump_done); // R8

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_busy, dma_busy})); // R9

endmodule

bind bus_mem_subsys bus_mem_subsys_chk #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_in     (bus_in),
  .lm         (lm),
  .addr_q     (addr_q),
  .addr_err   (addr_err),
  .ld_start   (ld_start),
  .ld_busy    (ld_busy),
  .dma_go     (dma_go),
  .dma_busy   (dma_busy),
  .dump_valid (dump_valid),
  .dump_addr  (dump_addr),
  .dump_done  (dump_done)
);

// File: tb/bus_mem_subsys_bench.sv
module bus_mem_subsys_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SW = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] bus_in = '0;
  logic          lm = 1'b0, lr = 1'b0, er = 1'b0;
  logic [DW-1:0] bus_out;
  logic          bus_oe;
  logic [AW-1:0] addr_q;
  logic          addr_err;
  logic          ld_start = 1'b0, ld_valid = 1'b0, ld_last = 1'b0;
  logic [DW-1:0] ld_byte = '0;
  logic          ld_busy;
  logic          dma_go = 1'b0;
  logic          dma_busy, dump_valid, dump_done;
  logic [AW-1:0] dump_addr;
  logic [DW-1:0] dump_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_mem_subsys #(.ADDR_W(AW), .DATA_W(DW), .SRC_W(SW)) u_bus_mem_subsys (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .lm(lm), .lr(lr), .er(er),
    .bus_out(bus_out), .bus_oe(bus_oe), .addr_q(addr_q), .addr_err(addr_err),
    .ld_start(ld_start), .ld_valid(ld_valid), .ld_byte(ld_byte), .ld_last(ld_last),
    .ld_busy(ld_busy), .dma_go(dma_go), .dma_busy(dma_busy), .dump_valid(dump_valid),
    .dump_addr(dump_addr), .dump_data(dump_data), .dump_done(dump_done)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Bench-side model state.
  logic [DW-1:0] m_mem [DEPTH];
  int            m_mar = 0;
  bit            m_err = 0;
  bit            m_fill = 0;
  int            m_ptr = 0;
  bit            m_dump = 0;
  int            m_dcnt = 0;
  bit            m_done = 0;

  function automatic bit fits(input int v);
    return v < DEPTH;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at the clock edge, with the inputs as the design sampled them.
  task automatic model_edge();
    bit was_busy;
    bit was_dump;
    was_busy = m_fill || m_dump;
    was_dump = m_dump;
    m_done = 0;
    if (m_fill) begin
      if (ld_valid) begin
        m_mem[m_ptr] = ld_byte;
        m_mar = m_ptr;
        if (ld_last || m_ptr == DEPTH-1) m_fill = 0;
        else m_ptr++;
      end
    end else if (!was_busy) begin
      if (lr) m_mem[m_mar] = bus_in[DW-1:0];
      if (lm) begin
        if (fits(int'(bus_in))) m_mar = int'(bus_in);
        else m_err = 1;
      end
      if (ld_start) begin
        m_fill = 1;
        m_ptr = 0;
      end else if (dma_go) begin
        m_dump = 1;
        m_dcnt = 0;
      end
    end
    if (was_dump) begin
      if (m_dcnt == DEPTH-1) begin
        m_dump = 0;
        m_done = 1;
      end else m_dcnt++;
    end
  endtask

  task automatic check_all();
    chk(addr_q == AW'(m_mar), "R1 addr_q", addr_q, m_mar);
    chk(addr_err == m_err, "R5 addr_err", addr_err, m_err);
    chk(ld_busy == m_fill, "R6 ld_busy", ld_busy, m_fill);
    chk(dma_busy == m_dump && dump_valid == m_dump, "R7 dump_valid", dump_valid, m_dump);
    chk(dump_done == m_done, "R8 dump_done", dump_done, m_done);
    if (m_dump) begin
      chk(dump_addr == AW'(m_dcnt), "R7 dump_addr", dump_addr, m_dcnt);
      chk(dump_data == m_mem[m_dcnt], "R7 dump_data", dump_data, m_mem[m_dcnt]);
    end
    chk(bus_oe == er, "R3 bus_oe", bus_oe, er);
    chk(bus_out == (er ? m_mem[m_mar] : '0), "R3 bus_out", bus_out,
        er ? m_mem[m_mar] : 0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    check_all();
  endtask

  task automatic idle_inputs();
    lm = 0; lr = 0; er = 0; ld_start = 0; ld_valid = 0; ld_last = 0; dma_go = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R4: reset state, including stored zeros.
    chk(addr_q == '0 && !addr_err, "R4 addr/err", {addr_err, addr_q}, 0);
    chk(!ld_busy && !dma_busy && !dump_valid && !dump_done, "R4 busy", {ld_busy, dma_busy}, 0);
    er = 1; #1;
    chk(bus_out == '0 && bus_oe, "R4 mem0", bus_out, 0);

    // R1/R2: directed load address, write, non-write clock.
    idle_inputs(); lm = 1; bus_in = 9'h00F; step();
    lm = 0; lr = 1; bus_in = 9'h0AB; step();
    lr = 0; bus_in = 9'h0AA; er = 1; step();
    chk(bus_out == 8'hAB, "R2 no-lr keep", bus_out, 8'hAB);
    // R2: write and load together, write lands at the old address.
    lm = 1; lr = 1; bus_in = 9'h033; step();
    lm = 1; lr = 0; bus_in = 9'h00F; step();
    chk(bus_out == 8'h33, "R2 same-edge old addr", bus_out, 8'h33);
    // R5: top legal address, then out of range.
    lm = 1; bus_in = 9'h0FF; step();
    lm = 1; bus_in = 9'h100; step();
    chk(addr_err && addr_q == 8'hFF, "R5 wide addr", {addr_err, addr_q}, 9'h1FF);
    lm = 1; bus_in = 9'h010; step();
    chk(addr_err, "R5 sticky", addr_err, 1);

    // Random processor traffic.
    for (int i = 0; i < 400; i++) begin
      idle_inputs();
      lm = ($urandom % 2) == 0;
      lr = ($urandom % 3) == 0;
      er = ($urandom % 2) == 0;
      bus_in = SW'($urandom % 256);
      if (($urandom % 16) == 0) bus_in[SW-1] = 1'b1;
      #1 chk(bus_out == (er ? m_mem[m_mar] : '0), "R3 comb read", bus_out, er ? m_mem[m_mar] : 0);
      step();
    end

    // R6: short fill with gaps; processor controls ignored (R9).
    idle_inputs(); ld_start = 1; step();
    ld_start = 0;
    for (int k = 0; k < 6; ) begin
      ld_valid = ($urandom % 3) != 0;
      ld_byte = DW'($urandom);
      ld_last = (k == 5);
      lm = 1; lr = 1; bus_in = 9'h0C0; er = 1;
      dma_go = 1;
      step();
      if (ld_valid) k++;
    end
    idle_inputs(); step();
    chk(!ld_busy && addr_q == 8'h05, "R6 fill end", addr_q, 5);
    // Re-address earlier locations.
    lm = 1; bus_in = 9'h000; step();
    er = 1; lm = 0; #1;
    chk(bus_out == m_mem[0], "R6 readback 0", bus_out, m_mem[0]);
    lm = 1; bus_in = 9'h003; step();

    // R6: full fill with no last marker ends at address 255.
    idle_inputs(); ld_start = 1; step();
    ld_start = 0;
    for (int k = 0; k < DEPTH; k++) begin
      ld_valid = 1; ld_byte = DW'(k * 7 + 3); step();
    end
    idle_inputs(); step();
    chk(!ld_busy && addr_q == 8'hFF, "R6 fill wrap stop", {ld_busy, addr_q}, 8'hFF);

    // R9: simultaneous strobes, fill wins.
    ld_start = 1; dma_go = 1; step();
    chk(ld_busy && !dma_busy, "R9 fill wins", {ld_busy, dma_busy}, 2);
    idle_inputs(); ld_valid = 1; ld_last = 1; ld_byte = 8'h5A; step();
    idle_inputs(); step();

    // R7/R8: full dump with disturbances.
    dma_go = 1; step();
    for (int k = 0; k < DEPTH + 3; k++) begin
      idle_inputs();
      lm = ($urandom % 2) == 0; lr = ($urandom % 2) == 0;
      bus_in = SW'($urandom % 256);
      ld_start = (k == 10);
      dma_go = (k == 20);
      step();
    end
    idle_inputs(); step(); step();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule